// File: doc/BRIEF.md
# Exception Entry Status Update Unit

This block computes, in a single registered step, every architectural state change a processor core makes when it takes an exception. The core presents the kind of exception being taken, the status word in force at that moment, the return address to be kept for the handler, and a configuration bit that selects big-endian data access. One clock later the block presents four results together: the rewritten status word, an untouched copy of the old status word for the saved-status register, the value for the target mode's link register, and the handler address for the program counter. A single-cycle `done` strobe marks them.

The request side is a valid/ready interface. `req_ready` is held high whenever reset is released, so the block never applies back-pressure: every cycle in which `req_valid` is high hands over one request, and back-to-back requests give back-to-back `done` pulses. The result side has no ready input. The core must capture the results in the cycle `done` is high. The results then stay unchanged until the next accepted request. The handler always starts in the 32-bit instruction state. Interrupt masks are raised according to the exception kind, and the remaining status bits are carried across unchanged.

Choosing between simultaneous exception requests and storing the banked registers are left to the surrounding core.

Top module: `exc_entry_unit`

## Requirements
- R1: `req_ready` is high whenever reset is not asserted. A request with a legal kind code (0 to 6) accepted on a clock edge raises `done` for exactly the following cycle. `done` is low in every cycle that does not follow an accepted legal request.
- R2: When `done` is high, `saved_status` equals the `cur_status` value of the accepted request, bit for bit.
- R3: When `done` is high, `link_out` equals the `ret_link` value of the accepted request.
- R4: `new_status[4:0]` carries the target mode number. Kind codes are 0 reset, 1 undefined instruction, 2 software interrupt, 3 prefetch abort, 4 data abort, 5 IRQ and 6 FIQ. The mode numbers are 0b10011 for reset and software interrupt, 0b11011 for undefined, 0b10111 for both aborts, 0b10010 for IRQ and 0b10001 for FIQ.
- R5: `new_status[5]`, the 16-bit instruction state flag, is 0 after every exception kind.
- R6: `new_status[6]`, the fast-interrupt mask, is 1 for reset (code 0) and FIQ (code 6). For every other kind it equals `cur_status[6]`.
- R7: `new_status[7]`, the interrupt mask, is 1 after every exception kind.
- R8: `new_status[8]`, the imprecise-abort mask, equals `cur_status[8]` for undefined (code 1) and software interrupt (code 2). For every other kind it is 1.
- R9: `new_status[9]` equals `cfg_big_end` as sampled with the request.
- R10: `vector_pc` is 0x00 for reset, 0x04 for undefined, 0x08 for software interrupt, 0x0C for prefetch abort, 0x10 for data abort, 0x18 for IRQ and 0x1C for FIQ.
- R11: `new_status[31:10]` equals `cur_status[31:10]`.
- R12: A request with kind code 7 is accepted but ignored. It produces no `done` pulse, and all four result outputs keep their previous values.
- R13: While reset is asserted and after it is released, `done` is 0 and all result outputs are 0 until the first legal request completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted when high together with valid |
| req_kind | input | 3 | Exception kind code (0..6 legal, 7 ignored) |
| cur_status | input | 32 | Status word in force when the exception is taken |
| ret_link | input | 32 | Return address for the handler |
| cfg_big_end | input | 1 | Data endianness to install in the new status |
| done | output | 1 | One-cycle strobe: results below are valid |
| new_status | output | 32 | Rewritten status word |
| saved_status | output | 32 | Copy of the previous status word |
| link_out | output | 32 | Value for the target mode's link register |
| vector_pc | output | 32 | Handler address for the program counter |

## Verification
The assertions check several properties on every cycle:
- `done` follows exactly the accepted legal requests.
- The saved status and the link value echo the request.
- The state flag is always cleared and the interrupt mask always set.
- The mode field always holds a privileged mode.
- The outputs hold still between strobes.

The per-kind behaviour can only be shown by the bench's sweeps over every kind code, several status patterns and both endian settings. This includes which masks are forced or kept, the exact mode numbers and vector addresses, and the pass-through of the upper bits. The bench sweep also covers the silent treatment of code 7.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;

  localparam int KIND_W = 3;
  localparam int MODE_W = 5;
  localparam int VIDX_W = 3;

  typedef enum logic [KIND_W-1:0] {
    EXK_RESET = 3'd0,
    EXK_UNDEF = 3'd1,
    EXK_SWI   = 3'd2,
    EXK_PABT  = 3'd3,
    EXK_DABT  = 3'd4,
    EXK_IRQ   = 3'd5,
    EXK_FIQ   = 3'd6,
    EXK_NONE  = 3'd7
  } exc_kind_e;

  // Per-kind attributes: target mode, mask actions and vector word index.
  typedef struct packed {
    logic              legal;
    logic [MODE_W-1:0] mode;
    logic              force_fmask;
    logic              force_amask;
    logic [VIDX_W-1:0] vec_idx;
  } exc_attr_t;

  // Status word bit positions that the rest of the core decodes.
  localparam int ST_STATE16 = 5;
  localparam int ST_FMASK   = 6;
  localparam int ST_IMASK   = 7;
  localparam int ST_AMASK   = 8;
  localparam int ST_ENDIAN  = 9;
  localparam int ST_UPPER   = 10;

endpackage

// File: rtl/exc_kind_decode.sv
module exc_kind_decode
  import exc_entry_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output exc_attr_t         attr
);

  always_comb begin
    attr = '0;
    unique case (exc_kind_e'(kind))
      EXK_RESET: attr = '{legal: 1'b1, mode: 5'b10011, force_fmask: 1'b1, force_amask: 1'b1, vec_idx: 3'd0};
      EXK_UNDEF: attr = '{legal: 1'b1, mode: 5'b11011, force_fmask: 1'b0, force_amask: 1'b0, vec_idx: 3'd1};
      EXK_SWI:   attr = '{legal: 1'b1, mode: 5'b10011, force_fmask: 1'b0, force_amask: 1'b0, vec_idx: 3'd2};
      EXK_PABT:  attr = '{legal: 1'b1, mode: 5'b10111, force_fmask: 1'b0, force_amask: 1'b1, vec_idx: 3'd3};
      EXK_DABT:  attr = '{legal: 1'b1, mode: 5'b10111, force_fmask: 1'b0, force_amask: 1'b1, vec_idx: 3'd4};
      EXK_IRQ:   attr = '{legal: 1'b1, mode: 5'b10010, force_fmask: 1'b0, force_amask: 1'b1, vec_idx: 3'd6};
      EXK_FIQ:   attr = '{legal: 1'b1, mode: 5'b10001, force_fmask: 1'b1, force_amask: 1'b1, vec_idx: 3'd7};
      default:   attr = '0;
    endcase
  end

endmodule

// File: rtl/exc_status_merge.sv
module exc_status_merge
  import exc_entry_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic [STAT_W-1:0] cur,
  input  exc_attr_t         attr,
  input  logic              big_end,
  output logic [STAT_W-1:0] merged,
  output logic [ADDR_W-1:0] vector
);

  localparam int VSHIFT = 2;

  // Upper bits are copied straight across.
  generate
    if (STAT_W > ST_UPPER) begin : g_upper
      assign merged[STAT_W-1:ST_UPPER] = cur[STAT_W-1:ST_UPPER];
    end
  endgenerate

  assign merged[MODE_W-1:0] = attr.mode;
  assign merged[ST_STATE16] = 1'b0;
  assign merged[ST_FMASK]   = attr.force_fmask | cur[ST_FMASK];
  assign merged[ST_IMASK]   = 1'b1;
  assign merged[ST_AMASK]   = attr.force_amask | cur[ST_AMASK];
  assign merged[ST_ENDIAN]  = big_end;

  always_comb begin
    vector = '0;
    vector[VIDX_W+VSHIFT-1:VSHIFT] = attr.vec_idx;
  end

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int STAT_W = 32,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [2:0]        req_kind,
  input  logic [STAT_W-1:0] cur_status,
  input  logic [ADDR_W-1:0] ret_link,
  input  logic              cfg_big_end,
  output logic              done,
  output logic [STAT_W-1:0] new_status,
  output logic [STAT_W-1:0] saved_status,
  output logic [ADDR_W-1:0] link_out,
  output logic [ADDR_W-1:0] vector_pc
);

  exc_attr_t         attr;
  logic [STAT_W-1:0] merged;
  logic [ADDR_W-1:0] vec;
  logic              take;
  logic              ready_q;

  exc_kind_decode u_dec (
    .kind (req_kind),
    .attr (attr)
  );

  exc_status_merge #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_merge (
    .cur     (cur_status),
    .attr    (attr),
    .big_end (cfg_big_end),
    .merged  (merged),
    .vector  (vec)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign req_ready = ready_q | rst_n;
  assign take      = req_valid & req_ready & attr.legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done         <= 1'b0;
      new_status   <= '0;
      saved_status <= '0;
      link_out     <= '0;
      vector_pc    <= '0;
    end else begin
      done <= take;
      if (take) begin
        new_status   <= merged;
        saved_status <= cur_status;
        link_out     <= ret_link;
        vector_pc    <= vec;
      end
    end
  end

endmodule

// File: rtl/exc_entry_checker.sv
module exc_entry_checker #(
  parameter int STAT_W = 32,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [2:0]        req_kind,
  input logic [STAT_W-1:0] cur_status,
  input logic [ADDR_W-1:0] ret_link,
  input logic              done,
  input logic [STAT_W-1:0] new_status,
  input logic [STAT_W-1:0] saved_status,
  input logic [ADDR_W-1:0] link_out,
  input logic [ADDR_W-1:0] vector_pc
);

  AST_READY_UP: assert property (@(posedge clk) disable iff (!rst_n) req_ready); // R1
  AST_DONE_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    done == $past(req_valid && req_ready && (req_kind != 3'd7))); // R1
  AST_SAVED_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> saved_status == $past(cur_status)); // R2
  AST_LINK_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> link_out == $past(ret_link)); // R3
  AST_MODE_PRIV: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_status[4]); // R4
  AST_STATE_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !new_status[5]); // R5
  AST_IMASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> new_status[7]); // R7
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(new_status) && $stable(vector_pc) && $stable(link_out))); // R12

endmodule

bind exc_entry_unit exc_entry_checker #(.STAT_W(STAT_W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .req_kind     (req_kind),
  .cur_status   (cur_status),
  .ret_link     (ret_link),
  .done         (done),
  .new_status   (new_status),
  .saved_status (saved_status),
  .link_out     (link_out),
  .vector_pc    (vector_pc)
);

// File: tb/tb_exc_entry_unit.sv
`timescale 1ns/1ps
module tb_exc_entry_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_kind = '0;
  logic [31:0] cur_status = '0;
  logic [31:0] ret_link = '0;
  logic        cfg_big_end = 1'b0;
  logic        done;
  logic [31:0] new_status, saved_status, link_out, vector_pc;

  int nvec = 0;
  int nfail = 0;

  logic [31:0] e_ns = '0, e_ss = '0, e_lk = '0, e_pc = '0;

  always #2 clk = ~clk;

  exc_entry_unit dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .cur_status(cur_status), .ret_link(ret_link),
    .cfg_big_end(cfg_big_end), .done(done), .new_status(new_status),
    .saved_status(saved_status), .link_out(link_out), .vector_pc(vector_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [4:0] mode_of(input logic [2:0] k);
    case (k)
      3'd0, 3'd2: return 5'b10011;
      3'd1:       return 5'b11011;
      3'd3, 3'd4: return 5'b10111;
      3'd5:       return 5'b10010;
      default:    return 5'b10001;
    endcase
  endfunction

  task automatic apply(input logic [2:0] k, input logic [31:0] st, input logic [31:0] lk, input logic be);
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; cur_status = st; ret_link = lk; cfg_big_end = be;
    chk("R1 ready", {31'd0, req_ready}, 32'd1);
    @(negedge clk);
    req_valid = 1'b0;
    if (k == 3'd7) begin
      chk("R12 no done", {31'd0, done}, 32'd0);
      chk("R12 status hold", new_status, e_ns);
      chk("R12 saved hold", saved_status, e_ss);
      chk("R12 link hold", link_out, e_lk);
      chk("R12 pc hold", vector_pc, e_pc);
    end else begin
      e_ns = st;
      e_ns[4:0] = mode_of(k);
      e_ns[5] = 1'b0;
      if (k == 3'd0 || k == 3'd6) e_ns[6] = 1'b1;
      e_ns[7] = 1'b1;
      if (k != 3'd1 && k != 3'd2) e_ns[8] = 1'b1;
      e_ns[9] = be;
      e_ss = st; e_lk = lk;
      e_pc = (k >= 3'd5) ? {27'd0, k + 3'd1, 2'b00} : {27'd0, k, 2'b00};
      chk("R1 done", {31'd0, done}, 32'd1);
      chk("R2 saved", saved_status, e_ss);
      chk("R3 link", link_out, e_lk);
      chk("R4 mode", {27'd0, new_status[4:0]}, {27'd0, e_ns[4:0]});
      chk("R5 state", {31'd0, new_status[5]}, 32'd0);
      chk("R6 fmask", {31'd0, new_status[6]}, {31'd0, e_ns[6]});
      chk("R7 imask", {31'd0, new_status[7]}, 32'd1);
      chk("R8 amask", {31'd0, new_status[8]}, {31'd0, e_ns[8]});
      chk("R9 endian", {31'd0, new_status[9]}, {31'd0, be});
      chk("R10 vector", vector_pc, e_pc);
      chk("R11 upper", {10'd0, new_status[31:10]}, {10'd0, st[31:10]});
    end
    @(negedge clk);
    chk("R1 single pulse", {31'd0, done}, 32'd0);
  endtask

  initial begin
    #(200000 * 4);
    nfail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    logic [31:0] pats [4];
    pats[0] = 32'h0000_0000; pats[1] = 32'hFFFF_FFFF;
    pats[2] = 32'hA5A5_5A5A; pats[3] = 32'h5A5A_A5A5;
    repeat (3) @(negedge clk);
    chk("R13 done in reset", {31'd0, done}, 32'd0);
    chk("R13 status in reset", new_status, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R13 done after reset", {31'd0, done}, 32'd0);
    chk("R13 pc after reset", vector_pc, 32'd0);
    chk("R13 link after reset", link_out, 32'd0);
    apply(3'd7, 32'h1234_5678, 32'h0000_0100, 1'b1);
    for (int p = 0; p < 4; p++)
      for (int b = 0; b < 2; b++)
        for (int k = 0; k < 8; k++)
          apply(3'(k), pats[p] ^ (32'h0101_0101 * k), 32'h8000_0000 + 32'(k * 16 + p), b[0]);
    for (int i = 0; i < 32; i++)
      apply(3'(i % 8), 32'h1 << i, ~(32'h1 << i), i[0]);
    // R1 back-to-back requests
    @(negedge clk);
    req_valid = 1'b1; req_kind = 3'd5; cur_status = 32'h0; ret_link = 32'h40; cfg_big_end = 1'b0;
    @(negedge clk);
    req_kind = 3'd6; ret_link = 32'h44;
    chk("R1 b2b first done", {31'd0, done}, 32'd1);
    chk("R10 b2b irq vector", vector_pc, 32'h18);
    @(negedge clk);
    req_valid = 1'b0;
    chk("R1 b2b second done", {31'd0, done}, 32'd1);
    chk("R10 b2b fiq vector", vector_pc, 32'h1C);
    chk("R3 b2b link", link_out, 32'h44);
    @(negedge clk);
    chk("R1 b2b idle", {31'd0, done}, 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

endmodule